// File: doc/BRIEF.md
# Instruction Bundle Group Hazard Checker

This block inspects a stream of 128-bit instruction bundles, one per clock, that a compiler has packed with three fixed-length operations each. A 5-bit format code at the low end of the bundle sets two things: which kind of execution unit each of the three slots feeds, and where the compiler placed group boundaries (stops). Operations between two stops form one group. The hardware may issue a group in parallel only if no member reads or rewrites a register that an earlier member of the same group writes.

For every accepted bundle the checker reports the following, one cycle later:
- the decoded unit kinds and stop positions;
- the major opcode and qualifying predicate of each slot;
- per-slot flags for read-after-write and write-after-write conflicts inside the open group;
- a summary hazard flag and the lowest offending slot.

Groups may run across several bundles. A register scoreboard carries the registers written so far in the open group from one bundle to the next, and it empties once a bundle that ends with a stop has been consumed. A read that comes before a write of the same register in the same group is legal. Format codes that do not belong to the table are flagged as illegal and have no effect on the scoreboard.

Top module: `bundle_group_checker`

## Requirements
- R1: `in_ready` is 0 while `rst` is high and becomes 1 from the first rising edge with `rst` low. A bundle is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `res_valid` is 1 in exactly the cycle after each accepted bundle and 0 otherwise.
- R2: The bundle is split as follows: format code in bits 4:0, slot 0 in bits 45:5, slot 1 in bits 86:46, slot 2 in bits 127:87. Within a slot the fields are: qualifying predicate in bits 5:0, destination in bits 12:6, source A in bits 19:13, source B in bits 26:20, major opcode in bits 40:37. Slot i's predicate is reported in `res_qp[6i+5:6i]` and its opcode in `res_opcode[4i+3:4i]`.
- R3: Unit codes are memory=0, integer=1, float=2, branch=3, long-immediate=4, and slot i's code is reported in `res_units[3i+2:3i]`. The slot kinds for each legal format code, with the low code bit masked off, are:
  - 0x00 memory/integer/integer
  - 0x02 memory/integer/integer
  - 0x04 memory/long/long
  - 0x08 memory/memory/integer
  - 0x0A memory/memory/integer
  - 0x0C memory/float/integer
  - 0x0E memory/memory/float
  - 0x10 memory/integer/branch
  - 0x12 memory/branch/branch
  - 0x16 branch/branch/branch
  - 0x18 memory/memory/branch
  - 0x1C memory/float/branch
- R4: `res_stops` bit i means a stop follows slot i. Every odd legal code sets bit 2, codes 0x02 and 0x03 set bit 1, codes 0x0A and 0x0B set bit 0, and no other stop bits are set.
- R5: Codes 0x06, 0x07, 0x14, 0x15, 0x1A, 0x1B, 0x1E and 0x1F set `res_bad_tmpl`. For such a bundle `res_units`, `res_stops`, `res_raw`, `res_waw` and `res_hazard` are 0, and the scoreboard is left unchanged.
- R6: `res_raw` bit i is 1 when either source of slot i names a register written by an earlier operation of the open group, in an earlier slot or an earlier bundle.
- R7: `res_waw` bit i is 1 when the destination of slot i names a register already written by an earlier operation of the open group.
- R8: A source that names a register written later in the same group is not a conflict. Neither is an operation whose source equals its own destination.
- R9: Register 0 is never recorded as written, so destination 0 never causes a later conflict and is never itself flagged.
- R10: The scoreboard is empty at the bundle after one whose code sets a final stop, and after reset. A stop after slot 0 or slot 1 cuts later slots off from earlier slots and earlier bundles.
- R11: `res_hazard` is the OR of all `res_raw` and `res_waw` bits. `res_slot` is the lowest slot index with a flag set, or 0 when none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle can be taken |
| in_bundle | input | 128 | Instruction bundle |
| res_valid | output | 1 | Result for the previous accepted bundle |
| res_bad_tmpl | output | 1 | Format code not in the table |
| res_units | output | 9 | Unit code per slot, 3 bits each |
| res_stops | output | 3 | Stop after slot i |
| res_opcode | output | 12 | Major opcode per slot, 4 bits each |
| res_qp | output | 18 | Qualifying predicate per slot, 6 bits each |
| res_raw | output | 3 | Read-after-write flag per slot |
| res_waw | output | 3 | Write-after-write flag per slot |
| res_hazard | output | 1 | Any conflict in this bundle |
| res_slot | output | 2 | Lowest conflicting slot |

## Verification
Every result field belongs to the bundle taken at a rising edge and is due right after that edge. The driver therefore presents bundles at falling edges and queues the expected record at the same moment. The monitor compares the head of that queue at the next falling edge on which `res_valid` is high, and it treats any `res_valid` with an empty queue as an error. Scoreboard effects such as clearing after a final stop, isolation by a mid-bundle stop and reset clearing show up only in the following bundle. Each of these is checked through the flags of a probe bundle sent right after it.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  localparam int TMPL_W = 5;
  localparam int SLOT_W = 41;
  localparam int NSLOT  = 3;
  localparam int REG_W  = 7;
  localparam int QP_W   = 6;
  localparam int OPC_W  = 4;
  localparam int UNIT_W = 3;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_MEM  = 3'd0,
    UNIT_INT  = 3'd1,
    UNIT_FLT  = 3'd2,
    UNIT_BRN  = 3'd3,
    UNIT_LIMM = 3'd4
  } unit_e;
endpackage

// File: rtl/bgc_template_rom.sv
module bgc_template_rom
  import bgc_pkg::*;
#(
  parameter int CODE_W = TMPL_W
) (
  input  logic [CODE_W-1:0]       code,
  output logic                    legal,
  output logic [NSLOT*UNIT_W-1:0] units,
  output logic [NSLOT-1:0]        stops
);
  localparam int BASE_W = CODE_W - 1;

  logic [BASE_W-1:0] base;
  logic [NSLOT-1:0]  mid;
  unit_e u0, u1, u2;

  assign base = code[CODE_W-1:1];

  // Row lookup on the code with its final-stop bit removed
  always_comb begin
    legal = 1'b1;
    mid   = '0;
    u0 = UNIT_MEM; u1 = UNIT_INT; u2 = UNIT_INT;
    case (base)
      BASE_W'(0):  begin end
      BASE_W'(1):  mid[1] = 1'b1;
      BASE_W'(2):  begin u1 = UNIT_LIMM; u2 = UNIT_LIMM; end
      BASE_W'(4):  u1 = UNIT_MEM;
      BASE_W'(5):  begin u1 = UNIT_MEM; mid[0] = 1'b1; end
      BASE_W'(6):  u1 = UNIT_FLT;
      BASE_W'(7):  begin u1 = UNIT_MEM; u2 = UNIT_FLT; end
      BASE_W'(8):  u2 = UNIT_BRN;
      BASE_W'(9):  begin u1 = UNIT_BRN; u2 = UNIT_BRN; end
      BASE_W'(11): begin u0 = UNIT_BRN; u1 = UNIT_BRN; u2 = UNIT_BRN; end
      BASE_W'(12): begin u1 = UNIT_MEM; u2 = UNIT_BRN; end
      BASE_W'(14): begin u1 = UNIT_FLT; u2 = UNIT_BRN; end
      default:     legal = 1'b0;
    endcase
  end

  always_comb begin
    if (legal) begin
      units = {u2, u1, u0};
      stops = mid;
      stops[NSLOT-1] = code[0];
    end else begin
      units = '0;
      stops = '0;
    end
  end
endmodule

// File: rtl/bgc_slot_split.sv
module bgc_slot_split
  import bgc_pkg::*;
#(
  parameter int CODE_W  = TMPL_W,
  parameter int INSN_W  = SLOT_W,
  parameter int SLOTS   = NSLOT,
  parameter int RID_W   = REG_W,
  parameter int PRED_W  = QP_W,
  parameter int MAJOR_W = OPC_W
) (
  input  logic [CODE_W+SLOTS*INSN_W-1:0]  bundle,
  output logic [CODE_W-1:0]               code,
  output logic [SLOTS-1:0][PRED_W-1:0]    qp,
  output logic [SLOTS-1:0][MAJOR_W-1:0]   opc,
  output logic [SLOTS-1:0][RID_W-1:0]     dst,
  output logic [SLOTS-1:0][RID_W-1:0]     srca,
  output logic [SLOTS-1:0][RID_W-1:0]     srcb
);
  localparam int DST_LSB  = PRED_W;
  localparam int SRCA_LSB = DST_LSB + RID_W;
  localparam int SRCB_LSB = SRCA_LSB + RID_W;
  localparam int OPC_LSB  = INSN_W - MAJOR_W;

  assign code = bundle[CODE_W-1:0];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [INSN_W-1:0] insn;
    assign insn    = bundle[CODE_W + i*INSN_W +: INSN_W];
    assign qp[i]   = insn[0 +: PRED_W];
    assign dst[i]  = insn[DST_LSB +: RID_W];
    assign srca[i] = insn[SRCA_LSB +: RID_W];
    assign srcb[i] = insn[SRCB_LSB +: RID_W];
    assign opc[i]  = insn[OPC_LSB +: MAJOR_W];
  end
endmodule

// File: rtl/bgc_group_tracker.sv
module bgc_group_tracker
  import bgc_pkg::*;
#(
  parameter int SLOTS = NSLOT,
  parameter int RID_W = REG_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         accept,
  input  logic                         legal,
  input  logic [SLOTS-1:0]             stops,
  input  logic [SLOTS-1:0][RID_W-1:0]  dst,
  input  logic [SLOTS-1:0][RID_W-1:0]  srca,
  input  logic [SLOTS-1:0][RID_W-1:0]  srcb,
  output logic [SLOTS-1:0]             raw,
  output logic [SLOTS-1:0]             waw
);
  localparam int NREG = 1 << RID_W;

  logic [NREG-1:0]             written_q, written_d;
  logic [SLOTS-1:0]            reach_prior;  // slot still in the group opened before this bundle
  logic [SLOTS-1:0][SLOTS-1:0] link;         // link[k][j]: slots k<j share a group
  logic [SLOTS-1:0]            survive;      // slot's write stays live past this bundle

  always_comb begin
    reach_prior[0] = 1'b1;
    for (int j = 1; j < SLOTS; j++)
      reach_prior[j] = reach_prior[j-1] & ~stops[j-1];

    link = '0;
    for (int j = 1; j < SLOTS; j++) begin
      link[j-1][j] = ~stops[j-1];
      for (int k = j - 2; k >= 0; k--)
        link[k][j] = link[k+1][j] & ~stops[k];
    end

    for (int k = 0; k < SLOTS - 1; k++)
      survive[k] = link[k][SLOTS-1];
    survive[SLOTS-1] = 1'b1;
  end

  // Conflict search: scoreboard for the carried part, pairwise compare inside the bundle
  always_comb begin
    logic hit_r, hit_w;
    for (int j = 0; j < SLOTS; j++) begin
      hit_r = reach_prior[j] & (written_q[srca[j]] | written_q[srcb[j]]);
      hit_w = reach_prior[j] & (dst[j] != '0) & written_q[dst[j]];
      for (int k = 0; k < j; k++) begin
        if (link[k][j] && dst[k] != '0) begin
          hit_r = hit_r | (dst[k] == srca[j]) | (dst[k] == srcb[j]);
          hit_w = hit_w | (dst[k] == dst[j]);
        end
      end
      raw[j] = legal & hit_r;
      waw[j] = legal & hit_w;
    end
  end

  always_comb begin
    written_d = written_q;
    if (accept && legal) begin
      if (stops[SLOTS-1] || !reach_prior[SLOTS-1])
        written_d = '0;
      if (!stops[SLOTS-1]) begin
        for (int k = 0; k < SLOTS; k++)
          if (survive[k] && dst[k] != '0)
            written_d[dst[k]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) written_q <= '0;
    else     written_q <= written_d;
  end
endmodule

// File: rtl/bundle_group_checker.sv
module bundle_group_checker
  import bgc_pkg::*;
#(
  parameter int CODE_W  = TMPL_W,
  parameter int INSN_W  = SLOT_W,
  parameter int SLOTS   = NSLOT,
  parameter int RID_W   = REG_W,
  parameter int PRED_W  = QP_W,
  parameter int MAJOR_W = OPC_W,
  parameter int KIND_W  = UNIT_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [CODE_W+SLOTS*INSN_W-1:0] in_bundle,
  output logic                        res_valid,
  output logic                        res_bad_tmpl,
  output logic [SLOTS*KIND_W-1:0]     res_units,
  output logic [SLOTS-1:0]            res_stops,
  output logic [SLOTS*MAJOR_W-1:0]    res_opcode,
  output logic [SLOTS*PRED_W-1:0]     res_qp,
  output logic [SLOTS-1:0]            res_raw,
  output logic [SLOTS-1:0]            res_waw,
  output logic                        res_hazard,
  output logic [$clog2(SLOTS)-1:0]    res_slot
);
  localparam int SEL_W = $clog2(SLOTS);

  logic                          accept;
  logic [CODE_W-1:0]             code;
  logic [SLOTS-1:0][PRED_W-1:0]  qp;
  logic [SLOTS-1:0][MAJOR_W-1:0] opc;
  logic [SLOTS-1:0][RID_W-1:0]   dst, srca, srcb;
  logic                          legal;
  logic [SLOTS*KIND_W-1:0]       units;
  logic [SLOTS-1:0]              stops, raw, waw;
  logic [SEL_W-1:0]              first;

  assign accept = in_valid & in_ready;

  bgc_slot_split #(
    .CODE_W(CODE_W), .INSN_W(INSN_W), .SLOTS(SLOTS),
    .RID_W(RID_W), .PRED_W(PRED_W), .MAJOR_W(MAJOR_W)
  ) u_split (
    .bundle(in_bundle), .code(code), .qp(qp), .opc(opc),
    .dst(dst), .srca(srca), .srcb(srcb)
  );

  bgc_template_rom #(.CODE_W(CODE_W)) u_rom (
    .code(code), .legal(legal), .units(units), .stops(stops)
  );

  bgc_group_tracker #(.SLOTS(SLOTS), .RID_W(RID_W)) u_track (
    .clk(clk), .rst(rst), .accept(accept), .legal(legal), .stops(stops),
    .dst(dst), .srca(srca), .srcb(srcb), .raw(raw), .waw(waw)
  );

  always_comb begin
    first = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (raw[i] || waw[i]) first = SEL_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready     <= 1'b0;
      res_valid    <= 1'b0;
      res_bad_tmpl <= 1'b0;
      res_units    <= '0;
      res_stops    <= '0;
      res_opcode   <= '0;
      res_qp       <= '0;
      res_raw      <= '0;
      res_waw      <= '0;
      res_hazard   <= 1'b0;
      res_slot     <= '0;
    end else begin
      in_ready  <= 1'b1;
      res_valid <= accept;
      if (accept) begin
        res_bad_tmpl <= ~legal;
        res_units    <= units;
        res_stops    <= stops;
        res_opcode   <= opc;
        res_qp       <= qp;
        res_raw      <= raw;
        res_waw      <= waw;
        res_hazard   <= |{raw, waw};
        res_slot     <= first;
      end
    end
  end
endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
  parameter int SLOTS = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     res_valid,
  input logic                     res_bad_tmpl,
  input logic [SLOTS-1:0]         res_stops,
  input logic [SLOTS-1:0]         res_raw,
  input logic [SLOTS-1:0]         res_waw,
  input logic                     res_hazard,
  input logic [$clog2(SLOTS)-1:0] res_slot
);
  logic group_closed;

  always_ff @(posedge clk) begin
    if (rst) group_closed <= 1'b1;
    else if (res_valid && !res_bad_tmpl) group_closed <= res_stops[SLOTS-1];
  end

  p_ready_reset_r1: assert property (@(posedge clk) rst |=> !in_ready);

  p_result_follows_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> res_valid);

  p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !res_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(res_raw) && $stable(res_waw));

  p_bad_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_bad_tmpl) |-> (res_raw == '0 && res_waw == '0 && res_stops == '0 && !res_hazard));

  p_fresh_group_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && group_closed) |-> (!res_raw[0] && !res_waw[0]));

  p_slot_points_r11: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hazard) |-> (((res_raw | res_waw) >> res_slot) & SLOTS'(1)) != '0);

  p_quiet_slot_r11: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hazard) |-> (res_slot == '0 && res_raw == '0 && res_waw == '0));
endmodule

bind bundle_group_checker bgc_checker #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_bad_tmpl(res_bad_tmpl), .res_stops(res_stops),
  .res_raw(res_raw), .res_waw(res_waw), .res_hazard(res_hazard), .res_slot(res_slot)
);

// File: tb/sim_bundle_group_checker.sv
module sim_bundle_group_checker;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_bundle = '0;
  logic         res_valid, res_bad_tmpl, res_hazard;
  logic [8:0]   res_units;
  logic [2:0]   res_stops, res_raw, res_waw;
  logic [11:0]  res_opcode;
  logic [17:0]  res_qp;
  logic [1:0]   res_slot;

  always #4 clk = ~clk;  // 125 MHz

  bundle_group_checker u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bundle(in_bundle),
    .res_valid(res_valid), .res_bad_tmpl(res_bad_tmpl), .res_units(res_units),
    .res_stops(res_stops), .res_opcode(res_opcode), .res_qp(res_qp), .res_raw(res_raw),
    .res_waw(res_waw), .res_hazard(res_hazard), .res_slot(res_slot)
  );

  typedef struct packed {
    logic       bad;
    logic [8:0] units;
    logic [2:0] stops;
    logic [11:0] opc;
    logic [17:0] qp;
    logic [2:0] raw;
    logic [2:0] waw;
    logic       haz;
    logic [1:0] slot;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_chk = 0, n_bad = 0;
  logic [127:0] open_regs = '0;   // reference model of the open group

  function automatic void chk(bit ok, string req, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (%s): actual=%0h expected=%0h", req, tag, act, exp);
    end
  endfunction

  // R3/R4/R5 reference table
  function automatic void ref_code(input logic [4:0] c, output logic ok,
                                   output logic [8:0] u, output logic [2:0] s);
    logic [2:0] a, b, d;
    ok = 1'b1; s = 3'b000; a = 3'd0; b = 3'd1; d = 3'd1;
    case (c[4:1])
      4'h0: ;
      4'h1: s[1] = 1'b1;
      4'h2: begin b = 3'd4; d = 3'd4; end
      4'h4: b = 3'd0;
      4'h5: begin b = 3'd0; s[0] = 1'b1; end
      4'h6: b = 3'd2;
      4'h7: begin b = 3'd0; d = 3'd2; end
      4'h8: d = 3'd3;
      4'h9: begin b = 3'd3; d = 3'd3; end
      4'hB: begin a = 3'd3; b = 3'd3; d = 3'd3; end
      4'hC: begin b = 3'd0; d = 3'd3; end
      4'hE: begin b = 3'd2; d = 3'd3; end
      default: ok = 1'b0;
    endcase
    s[2] = c[0];
    if (ok) u = {d, b, a};
    else begin u = '0; s = '0; end
  endfunction

  function automatic logic [40:0] insn(logic [3:0] op, logic [5:0] qp, logic [6:0] d,
                                       logic [6:0] a, logic [6:0] b);
    return {op, 10'h2A5, b, a, d, qp};
  endfunction

  function automatic logic [127:0] bun(logic [4:0] c, logic [40:0] s0, logic [40:0] s1,
                                       logic [40:0] s2);
    return {s2, s1, s0, c};
  endfunction

  // Sequential reference: walk slots in order, stop empties the open set
  task automatic model(input logic [127:0] b, output exp_t e);
    logic ok;
    logic [8:0] u;
    logic [2:0] s;
    ref_code(b[4:0], ok, u, s);
    e = '0;
    e.bad = !ok; e.units = u; e.stops = s;
    for (int i = 0; i < 3; i++) begin
      logic [40:0] w;
      w = b[5 + 41*i +: 41];
      e.qp[6*i +: 6]  = w[5:0];
      e.opc[4*i +: 4] = w[40:37];
      if (ok) begin
        e.raw[i] = open_regs[w[19:13]] | open_regs[w[26:20]];
        e.waw[i] = (w[12:6] != 0) && open_regs[w[12:6]];
        if (w[12:6] != 0) open_regs[w[12:6]] = 1'b1;
        if (s[i]) open_regs = '0;
      end
    end
    e.haz = |{e.raw, e.waw};
    e.slot = (e.raw[0] | e.waw[0]) ? 2'd0 : (e.raw[1] | e.waw[1]) ? 2'd1 :
             (e.raw[2] | e.waw[2]) ? 2'd2 : 2'd0;
  endtask

  task automatic send(input logic [127:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", {tag, " ready"}, in_ready, 1);
    model(b, e);
    in_valid  = 1'b1;
    in_bundle = b;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (expq.size() == 0) chk(1'b0, "R1", "unexpected result", 1, 0);
      else begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(res_bad_tmpl === e.bad, "R5", t, res_bad_tmpl, e.bad);
        chk(res_units === e.units, "R3", t, res_units, e.units);
        chk(res_stops === e.stops, "R4", t, res_stops, e.stops);
        chk(res_qp === e.qp && res_opcode === e.opc, "R2", t, {res_opcode, res_qp}, {e.opc, e.qp});
        chk(res_raw === e.raw, "R6", t, res_raw, e.raw);
        chk(res_waw === e.waw, "R7", t, res_waw, e.waw);
        chk(res_hazard === e.haz && res_slot === e.slot, "R11", t,
            {res_hazard, res_slot}, {e.haz, e.slot});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [40:0] nop;
    nop = insn(4'h1, 6'd0, 7'd0, 7'd0, 7'd0);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b0, "R1", "ready in reset", in_ready, 0);
    chk(res_valid === 1'b0, "R1", "valid in reset", res_valid, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(in_ready === 1'b1, "R1", "ready after reset", in_ready, 1);

    // R3 R4 R5: sweep all codes with harmless slots
    for (int c = 0; c < 32; c++)
      send(bun(5'(c), insn(4'(c), 6'(c), 7'd0, 7'd1, 7'd2), nop,
               insn(4'hF, 6'd63, 7'd0, 7'd3, 7'd0)), "R3 sweep");
    send(bun(5'h01, nop, nop, nop), "close");
    idle(2);

    // R6: read after write inside a bundle
    send(bun(5'h01, insn(4'h8, 6'd1, 7'd5, 7'd0, 7'd0),
                    insn(4'h9, 6'd2, 7'd0, 7'd5, 7'd0), nop), "R6 raw slot1");
    // R7: rewrite of the same register
    send(bun(5'h01, insn(4'h8, 6'd0, 7'd7, 7'd0, 7'd0), nop,
                    insn(4'h8, 6'd0, 7'd7, 7'd1, 7'd0)), "R7 waw slot2");
    // R8: read then write, and self read-write
    send(bun(5'h01, insn(4'h8, 6'd0, 7'd0, 7'd9, 7'd0),
                    insn(4'h8, 6'd0, 7'd9, 7'd0, 7'd0),
                    insn(4'h8, 6'd0, 7'd10, 7'd10, 7'd10)), "R8 war legal");
    // R9: register 0 writes are ignored
    send(bun(5'h01, insn(4'h8, 6'd0, 7'd0, 7'd0, 7'd0),
                    insn(4'h8, 6'd0, 7'd0, 7'd0, 7'd0),
                    insn(4'h8, 6'd0, 7'd11, 7'd0, 7'd0)), "R9 reg0");
    // R10: mid stop after slot 1 isolates slot 2
    send(bun(5'h02, insn(4'h8, 6'd0, 7'd3, 7'd0, 7'd0),
                    insn(4'h8, 6'd0, 7'd4, 7'd0, 7'd0),
                    insn(4'h8, 6'd0, 7'd20, 7'd3, 7'd4)), "R10 mid stop");
    send(bun(5'h00, insn(4'h8, 6'd0, 7'd0, 7'd20, 7'd0),
                    insn(4'h8, 6'd0, 7'd0, 7'd3, 7'd0),
                    insn(4'h8, 6'd0, 7'd20, 7'd0, 7'd0)), "R10 carried group");
    send(bun(5'h01, insn(4'h8, 6'd0, 7'd0, 7'd0, 7'd20), nop, nop), "R10 span bundles");
    send(bun(5'h00, insn(4'h8, 6'd0, 7'd0, 7'd20, 7'd20), nop, nop), "R10 cleared by stop");
    send(bun(5'h0B, insn(4'h8, 6'd0, 7'd30, 7'd0, 7'd0),
                    insn(4'h8, 6'd0, 7'd0, 7'd30, 7'd0), nop), "R10 stop after slot0");
    // R5: illegal code leaves the scoreboard alone
    send(bun(5'h1A, insn(4'h8, 6'd0, 7'd40, 7'd0, 7'd0), nop, nop), "R5 illegal write");
    send(bun(5'h01, insn(4'h8, 6'd0, 7'd0, 7'd40, 7'd0), nop, nop), "R5 no trace");
    // R10: reset empties the open group
    send(bun(5'h00, insn(4'h8, 6'd0, 7'd50, 7'd0, 7'd0), nop, nop), "R10 before reset");
    idle(2);
    rst = 1'b1;
    open_regs = '0;
    repeat (2) @(negedge clk);
    chk(in_ready === 1'b0, "R1", "ready in second reset", in_ready, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    send(bun(5'h01, insn(4'h8, 6'd0, 7'd0, 7'd50, 7'd0), nop, nop), "R10 reset clears");
    idle(1);

    // Streaming mix of all codes with a small register range
    for (int n = 0; n < 400; n++) begin
      logic [40:0] s[3];
      for (int k = 0; k < 3; k++)
        s[k] = insn(4'($urandom), 6'($urandom), 7'($urandom_range(0, 7)),
                    7'($urandom_range(0, 7)), 7'($urandom_range(0, 7)));
      send(bun(5'($urandom), s[0], s[1], s[2]), "R6 R7 stream");
      if (n % 37 == 5) idle(1);
    end
    idle(4);
    chk(expq.size() == 0, "R1", "all results seen", expq.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule